// File: doc/BRIEF.md
# I2C Prioritized Interrupt Vector Unit

This block sits beside an I2C bus engine and turns that engine's single-cycle event pulses into sticky flags, an enable mask and one interrupt vector. The events are arbitration lost, NACK received, register-access ready, receive data ready, transmit data ready, stop condition detected and addressed as a slave. Each pulse sets a flag. The flags appear in a status word together with two level signals from the engine: receive shift register full and bus busy.

Software reads a small register port. A read of the vector register returns the code of the most urgent pending event that is enabled, and it clears that event's flag in the same access. Repeated vector reads therefore hand out the pending events one at a time, most urgent first, until the code 0 comes back. A write of ones to the status register clears selected flags. The interrupt request line stays high while any enabled flag is pending.

Register addresses on `reg_addr`: 0 is the mask, 1 is the status word and 2 is the vector. Address 3 reads as zero. Read data is combinational from the current address and state. Writes, clears and flag updates take effect at the next rising clock edge.

Top module: `i2c_event_vectorizer`

## Requirements
- R1: After reset all event flags and all mask bits are 0, `vector_o` is 0 and `irq` is low.
- R2: A pulse on an event input sets its flag, visible on `status_o` after the next rising edge, at these bit positions: arbitration lost 0, NACK 1, access ready 2, receive ready 3, transmit ready 4, stop detected 5, addressed as slave 9. Status bit 11 follows `rx_shift_full` and bit 12 follows `bus_busy` directly. All other status bits read 0.
- R3: Writing address 0 loads the mask from `reg_wdata[6:0]`, which reads back on address 0. The mask bit order is arbitration lost 0, NACK 1, access ready 2, receive ready 3, transmit ready 4, stop detected 5, addressed as slave 6.
- R4: `vector_o`, also read at address 2, gives the code of the lowest-numbered event that is both pending and enabled, or 0 if there is none. The codes are: arbitration lost 1, NACK 2, access ready 3, receive ready 4, transmit ready 5, stop detected 6, addressed as slave 7.
- R5: `irq` is high exactly when at least one pending flag has its mask bit set.
- R6: Writing address 1 clears each flag at status bits 0, 1, 2, 5 and 9 where the written bit is 1. Written zeros leave those flags unchanged.
- R7: A status write never changes the receive-ready or transmit-ready flags (status bits 3 and 4).
- R8: A read of address 2 clears the flag of the event whose code it returns. Repeated reads with no new events return the enabled pending codes in strictly increasing order, then 0.
- R9: An event pulse that arrives in the same cycle as a clear of its own flag, by a status write or by a vector read, leaves the flag set.
- R10: A flag whose mask bit is 0 still sets and shows in the status word, but it does not affect `vector_o` or `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_arb_lost | input | 1 | Arbitration-lost event pulse |
| ev_nack | input | 1 | NACK event pulse |
| ev_acc_rdy | input | 1 | Register-access-ready event pulse |
| ev_rx_rdy | input | 1 | Receive-ready event pulse |
| ev_tx_rdy | input | 1 | Transmit-ready event pulse |
| ev_stop | input | 1 | Stop-detected event pulse |
| ev_slave_hit | input | 1 | Addressed-as-slave event pulse |
| rx_shift_full | input | 1 | Receive shift register full level |
| bus_busy | input | 1 | Bus busy level |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data |
| status_o | output | DW | Status word |
| vector_o | output | 3 | Current interrupt vector code |
| irq | output | 1 | Interrupt request |

## Verification
A wrong flag shows on `status_o` one cycle after the pulse or the clear that produced it. A wrong priority or mask decision shows on `vector_o` and `irq` in the same cycle, because both outputs are combinational from the flags. A clear-on-read that removes the wrong source shows up a few cycles later as a missing or repeated code in the drain sequence. For this reason every pending pattern is drained in full and the whole sequence of codes is compared, not just the first code.

// File: rtl/i2c_event_vectorizer.sv
module i2c_event_vectorizer #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_arb_lost,
  input  logic          ev_nack,
  input  logic          ev_acc_rdy,
  input  logic          ev_rx_rdy,
  input  logic          ev_tx_rdy,
  input  logic          ev_stop,
  input  logic          ev_slave_hit,
  input  logic          rx_shift_full,
  input  logic          bus_busy,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [DW-1:0] status_o,
  output logic [2:0]    vector_o,
  output logic          irq
);
  localparam int NSRC = 7;
  localparam logic [1:0] A_MASK = 2'd0, A_STAT = 2'd1, A_VEC = 2'd2;

  logic [NSRC-1:0] pend, mask, act, ev, wr_clr, rd_clr;
  logic [2:0] vec;

  assign ev  = {ev_slave_hit, ev_stop, ev_tx_rdy, ev_rx_rdy, ev_acc_rdy, ev_nack, ev_arb_lost};
  assign act = pend & mask;
  assign irq = |act;

  always_comb begin
    vec = '0;
    for (int i = NSRC-1; i >= 0; i--)
      if (act[i]) vec = 3'(i + 1);
  end
  assign vector_o = vec;

  assign wr_clr = (reg_wr && reg_addr == A_STAT)
                ? {reg_wdata[9], reg_wdata[5], 2'b00, reg_wdata[2:0]} : '0;
  assign rd_clr = (reg_rd && reg_addr == A_VEC && vec != 3'd0)
                ? NSRC'(1) << (vec - 3'd1) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      mask <= '0;
    end else begin
      pend <= (pend & ~(wr_clr | rd_clr)) | ev;
      if (reg_wr && reg_addr == A_MASK) mask <= reg_wdata[NSRC-1:0];
    end
  end

  always_comb begin
    status_o     = '0;
    status_o[4:0] = pend[4:0];
    status_o[5]  = pend[5];
    status_o[9]  = pend[6];
    status_o[11] = rx_shift_full;
    status_o[12] = bus_busy;
  end

  always_comb begin
    case (reg_addr)
      A_MASK:  reg_rdata = DW'(mask);
      A_STAT:  reg_rdata = status_o;
      A_VEC:   reg_rdata = DW'(vec);
      default: reg_rdata = '0;
    endcase
  end
endmodule

module i2c_event_vectorizer_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_arb_lost,
  input logic          ev_nack,
  input logic          ev_acc_rdy,
  input logic          ev_rx_rdy,
  input logic          ev_tx_rdy,
  input logic          ev_stop,
  input logic          ev_slave_hit,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [1:0]    reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] status_o,
  input logic [2:0]    vector_o,
  input logic          irq
);
  logic no_ev;
  assign no_ev = !(ev_arb_lost | ev_nack | ev_acc_rdy | ev_rx_rdy | ev_tx_rdy | ev_stop | ev_slave_hit);

  p_irq_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (vector_o != 3'd0));

  p_arb_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb_lost |=> status_o[0]);

  p_slave_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_slave_hit |=> status_o[9]);

  p_w1c_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && reg_wdata[2] && !ev_acc_rdy) |=> !status_o[2]);

  p_rx_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && status_o[3]) |=> status_o[3]);

  p_keep_on_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && ev_stop) |=> status_o[5]);

  p_drain_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_addr == 2'd2 && vector_o != 3'd0 && no_ev)
      |=> (vector_o == 3'd0 || vector_o > $past(vector_o)));
endmodule

bind i2c_event_vectorizer i2c_event_vectorizer_chk #(.DW(DW)) chk (
  .clk(clk), .rst_n(rst_n),
  .ev_arb_lost(ev_arb_lost), .ev_nack(ev_nack), .ev_acc_rdy(ev_acc_rdy),
  .ev_rx_rdy(ev_rx_rdy), .ev_tx_rdy(ev_tx_rdy), .ev_stop(ev_stop),
  .ev_slave_hit(ev_slave_hit), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .status_o(status_o),
  .vector_o(vector_o), .irq(irq)
);

// File: tb/tb_i2c_event_vectorizer.sv
`timescale 1ns/1ps
module tb_i2c_event_vectorizer;
  localparam int DW = 16;
  logic clk = 0, rst_n = 0;
  logic [6:0] evs = '0;
  logic rx_shift_full = 0, bus_busy = 0, reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata, status_o;
  logic [2:0] vector_o;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2c_event_vectorizer #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .ev_arb_lost(evs[0]), .ev_nack(evs[1]), .ev_acc_rdy(evs[2]), .ev_rx_rdy(evs[3]),
    .ev_tx_rdy(evs[4]), .ev_stop(evs[5]), .ev_slave_hit(evs[6]),
    .rx_shift_full(rx_shift_full), .bus_busy(bus_busy),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .status_o(status_o), .vector_o(vector_o), .irq(irq));

  function automatic logic [15:0] stat_of(logic [6:0] f, logic sf, logic bb);
    logic [15:0] s = '0;
    s[4:0] = f[4:0]; s[5] = f[5]; s[9] = f[6]; s[11] = sf; s[12] = bb;
    return s;
  endfunction

  function automatic logic [2:0] low_code(logic [6:0] v);
    for (int i = 0; i < 7; i++) if (v[i]) return 3'(i + 1);
    return 3'd0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); #1; endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; step(); reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    reg_rd = 1; reg_addr = a; #1 d = reg_rdata; step(); reg_rd = 0;
  endtask

  task automatic pulse(logic [6:0] p);
    evs = p; step(); evs = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [6:0] rem;
    logic [6:0] masks [4] = '{7'h7F, 7'h00, 7'h55, 7'h2A};
    repeat (3) step();
    rst_n = 1; #1;
    chk("R1 status", status_o, 0);
    chk("R1 vector", vector_o, 0);
    chk("R1 irq", irq, 0);
    rd(2'd0, d); chk("R1 mask", d, 0);

    rx_shift_full = 1; #1 chk("R2 shift full level", status_o, 16'h0800);
    bus_busy = 1; rx_shift_full = 0; #1 chk("R2 busy level", status_o, 16'h1000);
    bus_busy = 0;

    for (int mi = 0; mi < 4; mi++) begin
      wr(2'd0, 16'(masks[mi]));
      rd(2'd0, d); chk("R3 mask readback", d, 16'(masks[mi]));
      for (int p = 0; p < 128; p++) begin
        wr(2'd0, 16'(masks[mi]));
        pulse(7'(p));
        #1;
        chk("R2 status after events", status_o, stat_of(7'(p), 0, 0));
        chk("R5 irq", irq, |(7'(p) & masks[mi]));
        chk("R4/R10 vector", vector_o, low_code(7'(p) & masks[mi]));
        rem = 7'(p);
        for (int k = 0; k < 8; k++) begin
          rd(2'd2, d);
          chk("R8 drain code", d, low_code(rem & masks[mi]));
          if (d == 0) break;
          rem[d-1] = 1'b0;
        end
        chk("R10 masked flags remain", status_o, stat_of(rem, 0, 0));
        wr(2'd1, 16'h0000);
        chk("R6 zero write no effect", status_o, stat_of(rem, 0, 0));
        wr(2'd1, 16'hFFFF);
        rem = rem & 7'b0011000;
        chk("R6/R7 w1c", status_o, stat_of(rem, 0, 0));
        wr(2'd0, 16'h007F);
        for (int k = 0; k < 3; k++) begin
          rd(2'd2, d);
          chk("R8 cleanup drain", d, low_code(rem));
          if (d == 0) break;
          rem[d-1] = 1'b0;
        end
        chk("R8 empty after drain", status_o, 0);
      end
    end

    wr(2'd0, 16'h007F);
    pulse(7'b0000100);
    reg_wr = 1; reg_addr = 2'd1; reg_wdata = 16'h0004; evs = 7'b0000100;
    step(); reg_wr = 0; evs = '0;
    chk("R9 event beats w1c", status_o, 16'h0004);
    chk("R9 vector", vector_o, 3);
    pulse(7'b0000001);
    chk("R4 priority", vector_o, 1);
    reg_rd = 1; reg_addr = 2'd2; evs = 7'b0000001;
    #1 chk("R8 read code", reg_rdata, 1);
    step(); reg_rd = 0; evs = '0;
    chk("R9 event beats read clear", status_o, 16'h0005);
    rd(2'd3, d); chk("R4 unused address", d, 0);
    rst_n = 0; step(); rst_n = 1; #1;
    chk("R1 reset clears", status_o, 0);
    chk("R1 reset irq", irq, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule